// File: doc/BRIEF.md
# Strobe-Addressed System Control and Status Register

This block holds a 16-bit system control and status word. Software never writes a value into it. Each control action has a dedicated byte offset, and a write strobe at that offset performs the action. The block has no data input on the write side. Set and clear actions have separate offsets, spaced four bytes apart. Some offsets clear latched error flags. One offset issues a system reset request.

Hardware event pulses latch the error and timer-tick flags. Four device interrupt lines are mirrored into the low bits. Clearing the timer-inhibit control also sends a one-clock reload pulse to every timer that is flagged active at that moment.

Reads are combinational. Software can fetch the whole word or one selected byte.

Top module: `strobe_csr`

## Requirements
- R1: A synchronous reset sets all 16 register bits, `sys_rst_req` and `tmr_reload` to 0.
- R2: The bit positions are fixed as follows:
  - device interrupt lines occupy bits 3..0
  - bit 4 is the high software interrupt
  - bit 5 is the low software interrupt
  - bit 6 is the timer tick
  - bit 7 is the fault mask
  - bit 8 is the timer mask
  - bit 9 is the motor control
  - bit 11 is the lamp
  - bit 12 is the misalignment flag
  - bit 14 is the parity flag
  - bit 15 is the bus-timeout flag
  - bits 10 and 13 always read 0
- R3: Reads are combinational.
  - At `rd_ofs`=2 the read returns the full word when `rd_byte`=0, and bits 15..8 when `rd_byte`=1.
  - At `rd_ofs`=3 the read returns bits 7..0.
  - Every other offset reads as 0.
- R4: A write strobe clears a latched error flag in the following cycle:
  - offset 0x03 clears bit 15
  - offset 0x07 clears bit 14
  - offset 0x0F clears bit 12
- R5: Each control bit has a set offset and a clear offset four bytes higher. The clear offset is the set offset plus 4, and the change is visible one cycle after the strobe:

  | Control | Set offset | Clear offset |
  |---|---|---|
  | lamp | 0x13 | 0x17 |
  | motor | 0x1B | 0x1F |
  | timer mask | 0x23 | 0x27 |
  | fault mask | 0x2B | 0x2F |
  | high software interrupt | 0x33 | 0x37 |
  | low software interrupt | 0x3B | 0x3F |

- R6: A write to offset 0x0B raises `sys_rst_req` for exactly one cycle after the strobe and leaves the register unchanged.
- R7: A write to offset 0x27 clears bit 8. For exactly one cycle after the strobe it drives `tmr_reload` with the `tmr_active` value sampled at the strobe. `tmr_reload` is 0 at all other times.
- R8: Single-cycle event inputs set flags that stay latched:
  - `bus_tmo_evt` sets bit 15
  - `parity_evt` sets bit 14
  - `misalign_evt` sets bit 12
  - `tick_evt` sets bit 6

  `tick_ack` clears bit 6. When a set and a clear reach the same bit in the same cycle, the set wins.
- R9: `dev_irq[3:0]` appears in bits 3..0 one cycle later.
- R10: A write strobe at an offset whose low two bits are not 11 changes no bit and issues no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe; the offset selects the action |
| wr_ofs | input | 6 | Byte offset of the write |
| rd_ofs | input | 6 | Byte offset of the read |
| rd_byte | input | 1 | 1 for a byte read, 0 for a halfword read |
| rd_data | output | 16 | Read data |
| dev_irq | input | 4 | Device interrupt levels |
| bus_tmo_evt | input | 1 | Bus timeout event pulse |
| parity_evt | input | 1 | Memory parity error pulse |
| misalign_evt | input | 1 | Alignment fault pulse |
| tick_evt | input | 1 | Timer tick pulse |
| tick_ack | input | 1 | Tick acknowledge pulse; clears the tick flag |
| tmr_active | input | NTMR | Per-timer flag: gate open and counting |
| csr_q | output | 16 | Current register value |
| sys_rst_req | output | 1 | One-clock system reset request |
| tmr_reload | output | NTMR | One-clock reload pulse for each timer |

## Verification
The hardest situation to create is a set and a clear that collide on the same bit in the same cycle. A hardware event must arrive on exactly the clock edge that also captures a software clear strobe, or a tick acknowledge. The directed tasks drive both inputs on the same falling edge and release them one cycle later, so the two land on one rising edge. The reload pulse also needs care, because it depends on the timer-active pattern at the moment of the strobe. The bench therefore presents a sparse active pattern before it issues the clear, and checks that the pulse repeats that pattern exactly once.

// File: rtl/strobe_csr_pkg.sv
package strobe_csr_pkg;

    localparam int CSR_W = 16;
    localparam int OFS_W = 6;
    localparam int SEL_W = $clog2(CSR_W);

    // bit positions
    localparam int B_SWI_HI   = 4;
    localparam int B_SWI_LO   = 5;
    localparam int B_TICK     = 6;
    localparam int B_FLT_MASK = 7;
    localparam int B_TMR_MASK = 8;
    localparam int B_MOTOR    = 9;
    localparam int B_LAMP     = 11;
    localparam int B_MISALIGN = 12;
    localparam int B_PARITY   = 14;
    localparam int B_BUS_TMO  = 15;
    localparam int IRQ_LINES  = 4;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_SET,
        ACT_CLR,
        ACT_SYSRST
    } act_e;

    typedef struct packed {
        act_e             act;
        logic [SEL_W-1:0] sel;
        logic             reload;
    } cmd_t;

    typedef enum logic [1:0] {
        KIND_LATCH,
        KIND_LEVEL,
        KIND_ZERO
    } kind_e;

    function automatic kind_e bit_kind(input int idx);
        if (idx < IRQ_LINES) return KIND_LEVEL;
        if (idx == 10 || idx == 13) return KIND_ZERO;
        return KIND_LATCH;
    endfunction

    function automatic cmd_t mk(input act_e a, input int b, input logic rl);
        cmd_t c;
        c.act    = a;
        c.sel    = SEL_W'(b);
        c.reload = rl;
        return c;
    endfunction

    // Slot = offset[5:2]; a strobe counts only when offset[1:0] == 2'b11.
    function automatic cmd_t decode_ofs(input logic [OFS_W-1:0] ofs);
        cmd_t c;
        c = mk(ACT_NONE, 0, 1'b0);
        if (ofs[1:0] == 2'b11) begin
            case (ofs[5:2])
                4'd0:  c = mk(ACT_CLR,    B_BUS_TMO,  1'b0);
                4'd1:  c = mk(ACT_CLR,    B_PARITY,   1'b0);
                4'd2:  c = mk(ACT_SYSRST, 0,          1'b0);
                4'd3:  c = mk(ACT_CLR,    B_MISALIGN, 1'b0);
                4'd4:  c = mk(ACT_SET,    B_LAMP,     1'b0);
                4'd5:  c = mk(ACT_CLR,    B_LAMP,     1'b0);
                4'd6:  c = mk(ACT_SET,    B_MOTOR,    1'b0);
                4'd7:  c = mk(ACT_CLR,    B_MOTOR,    1'b0);
                4'd8:  c = mk(ACT_SET,    B_TMR_MASK, 1'b0);
                4'd9:  c = mk(ACT_CLR,    B_TMR_MASK, 1'b1);
                4'd10: c = mk(ACT_SET,    B_FLT_MASK, 1'b0);
                4'd11: c = mk(ACT_CLR,    B_FLT_MASK, 1'b0);
                4'd12: c = mk(ACT_SET,    B_SWI_HI,   1'b0);
                4'd13: c = mk(ACT_CLR,    B_SWI_HI,   1'b0);
                4'd14: c = mk(ACT_SET,    B_SWI_LO,   1'b0);
                default: c = mk(ACT_CLR,  B_SWI_LO,   1'b0);
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/strobe_csr_dec.sv
module strobe_csr_dec
    import strobe_csr_pkg::*;
(
    input  logic             wr_stb,
    input  logic [OFS_W-1:0] wr_ofs,
    output logic [CSR_W-1:0] sw_set,
    output logic [CSR_W-1:0] sw_clr,
    output logic             rst_hit,
    output logic             reload_hit
);
    cmd_t cmd;

    always_comb begin
        cmd        = decode_ofs(wr_ofs);
        sw_set     = '0;
        sw_clr     = '0;
        rst_hit    = 1'b0;
        reload_hit = 1'b0;
        if (wr_stb) begin
            unique case (cmd.act)
                ACT_SET:    sw_set[cmd.sel] = 1'b1;
                ACT_CLR:    sw_clr[cmd.sel] = 1'b1;
                ACT_SYSRST: rst_hit         = 1'b1;
                default:    ;
            endcase
            reload_hit = cmd.reload;
        end
    end
endmodule

// File: rtl/strobe_csr_cell.sv
module strobe_csr_cell
    import strobe_csr_pkg::*;
#(
    parameter kind_e KIND = KIND_LATCH
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic lvl,
    output logic q
);
    generate
        if (KIND == KIND_LATCH) begin : g_latch
            logic unused_lvl;
            assign unused_lvl = lvl;
            always_ff @(posedge clk) begin
                if (rst)      q <= 1'b0;
                else if (set) q <= 1'b1;   // set has priority over clear
                else if (clr) q <= 1'b0;
            end
        end else if (KIND == KIND_LEVEL) begin : g_level
            logic unused_sc;
            assign unused_sc = set ^ clr;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= lvl;
            end
        end else begin : g_zero
            logic unused_all;
            assign unused_all = set ^ clr ^ lvl ^ clk ^ rst;
            assign q = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/strobe_csr_rdmux.sv
module strobe_csr_rdmux
    import strobe_csr_pkg::*;
(
    input  logic [CSR_W-1:0] word,
    input  logic [OFS_W-1:0] rd_ofs,
    input  logic             rd_byte,
    output logic [CSR_W-1:0] rd_data
);
    localparam int HALF = CSR_W / 2;

    always_comb begin
        rd_data = '0;
        if (rd_ofs == OFS_W'(2)) begin
            rd_data = rd_byte ? {{HALF{1'b0}}, word[CSR_W-1:HALF]} : word;
        end else if (rd_ofs == OFS_W'(3)) begin
            rd_data = {{HALF{1'b0}}, word[HALF-1:0]};
        end
    end
endmodule

// File: rtl/strobe_csr.sv
module strobe_csr
    import strobe_csr_pkg::*;
#(
    parameter int NTMR = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_stb,
    input  logic [OFS_W-1:0]       wr_ofs,
    input  logic [OFS_W-1:0]       rd_ofs,
    input  logic                   rd_byte,
    output logic [CSR_W-1:0]       rd_data,
    input  logic [IRQ_LINES-1:0]   dev_irq,
    input  logic                   bus_tmo_evt,
    input  logic                   parity_evt,
    input  logic                   misalign_evt,
    input  logic                   tick_evt,
    input  logic                   tick_ack,
    input  logic [NTMR-1:0]        tmr_active,
    output logic [CSR_W-1:0]       csr_q,
    output logic                   sys_rst_req,
    output logic [NTMR-1:0]        tmr_reload
);
    logic [CSR_W-1:0] sw_set, sw_clr, hw_set, hw_clr, lvl;
    logic             rst_hit, reload_hit;

    strobe_csr_dec u_dec (
        .wr_stb     (wr_stb),
        .wr_ofs     (wr_ofs),
        .sw_set     (sw_set),
        .sw_clr     (sw_clr),
        .rst_hit    (rst_hit),
        .reload_hit (reload_hit)
    );

    always_comb begin
        hw_set              = '0;
        hw_set[B_BUS_TMO]   = bus_tmo_evt;
        hw_set[B_PARITY]    = parity_evt;
        hw_set[B_MISALIGN]  = misalign_evt;
        hw_set[B_TICK]      = tick_evt;
        hw_clr              = '0;
        hw_clr[B_TICK]      = tick_ack;
        lvl                 = '0;
        lvl[IRQ_LINES-1:0]  = dev_irq;
    end

    genvar i;
    generate
        for (i = 0; i < CSR_W; i++) begin : g_bit
            strobe_csr_cell #(.KIND(bit_kind(i))) u_cell (
                .clk (clk),
                .rst (rst),
                .set (sw_set[i] | hw_set[i]),
                .clr (sw_clr[i] | hw_clr[i]),
                .lvl (lvl[i]),
                .q   (csr_q[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_rst_req <= 1'b0;
            tmr_reload  <= '0;
        end else begin
            sys_rst_req <= rst_hit;
            tmr_reload  <= reload_hit ? tmr_active : '0;
        end
    end

    strobe_csr_rdmux u_rd (
        .word    (csr_q),
        .rd_ofs  (rd_ofs),
        .rd_byte (rd_byte),
        .rd_data (rd_data)
    );

    // R8
    tmo_latch_chk: assert property (@(posedge clk) disable iff (rst)
        bus_tmo_evt |=> csr_q[B_BUS_TMO]);

    // R8
    tick_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_evt && tick_ack) |=> csr_q[B_TICK]);

    // R6
    rstreq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_ofs == 6'h0B) |=> sys_rst_req);

    // R5
    lamp_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_ofs == 6'h13) |=> csr_q[B_LAMP]);

    // R7
    reload_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (|tmr_reload) |-> !csr_q[B_TMR_MASK]);

    // R10
    undef_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_ofs[1:0] != 2'b11) |=>
            ($stable(csr_q[11:7]) && $stable(csr_q[5:4]) && !sys_rst_req && tmr_reload == '0));

    // R2
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !csr_q[10] && !csr_q[13]);
endmodule

// File: tb/sim_strobe_csr.sv
module sim_strobe_csr;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_stb = 1'b0;
    logic [5:0] wr_ofs = '0;
    logic [5:0] rd_ofs = '0;
    logic rd_byte = 1'b0;
    logic [15:0] rd_data;
    logic [3:0] dev_irq = '0;
    logic bus_tmo_evt = 0, parity_evt = 0, misalign_evt = 0, tick_evt = 0, tick_ack = 0;
    logic [NT-1:0] tmr_active = '0;
    logic [15:0] csr_q;
    logic sys_rst_req;
    logic [NT-1:0] tmr_reload;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_csr #(.NTMR(NT)) u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_ofs(wr_ofs),
        .rd_ofs(rd_ofs), .rd_byte(rd_byte), .rd_data(rd_data),
        .dev_irq(dev_irq), .bus_tmo_evt(bus_tmo_evt), .parity_evt(parity_evt),
        .misalign_evt(misalign_evt), .tick_evt(tick_evt), .tick_ack(tick_ack),
        .tmr_active(tmr_active), .csr_q(csr_q), .sys_rst_req(sys_rst_req),
        .tmr_reload(tmr_reload)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic do_wr(input logic [5:0] o);
        @(negedge clk); wr_stb = 1'b1; wr_ofs = o;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 word", csr_q, 16'h0000);
        chk("R1 rstreq", sys_rst_req, 0);
        chk("R1 reload", tmr_reload, 0);
    endtask

    task automatic t_pairs();
        int bits [6] = '{11, 9, 8, 7, 4, 5};
        logic [5:0] so [6] = '{6'h13, 6'h1B, 6'h23, 6'h2B, 6'h33, 6'h3B};
        for (int k = 0; k < 6; k++) begin
            do_wr(so[k]);
            chk("R5 set", csr_q, 32'(16'h1 << bits[k]));
            do_wr(so[k] + 6'd4);
            chk("R5 clear", csr_q, 16'h0000);
        end
        // all controls on: spare bits must stay 0
        for (int k = 0; k < 6; k++) do_wr(so[k]);
        chk("R2 all controls", csr_q, 16'h0BB0);
        chk("R2 spare", csr_q & 16'h2400, 0);
    endtask

    task automatic t_undef();
        logic [5:0] bad [6] = '{6'h00, 6'h01, 6'h02, 6'h12, 6'h25, 6'h3E};
        for (int k = 0; k < 6; k++) begin
            do_wr(bad[k]);
            chk("R10 word", csr_q, 16'h0BB0);
            chk("R10 pulses", {sys_rst_req, tmr_reload}, 0);
        end
    endtask

    task automatic t_sysrst();
        do_wr(6'h0B);
        chk("R6 pulse", sys_rst_req, 1);
        chk("R6 word", csr_q, 16'h0BB0);
        @(negedge clk);
        chk("R6 one cycle", sys_rst_req, 0);
    endtask

    task automatic t_reload();
        tmr_active = 3'b101;
        do_wr(6'h27);
        chk("R7 reload", tmr_reload, 3'b101);
        chk("R7 mask clear", csr_q, 16'h0AB0);
        tmr_active = 3'b111;
        @(negedge clk);
        chk("R7 one cycle", tmr_reload, 0);
        tmr_active = 3'b000;
    endtask

    task automatic t_read();
        rd_ofs = 6'd2; rd_byte = 1'b0; #1 chk("R3 half", rd_data, 16'h0AB0);
        rd_byte = 1'b1;               #1 chk("R3 hi byte", rd_data, 16'h000A);
        rd_ofs = 6'd3; rd_byte = 1'b1; #1 chk("R3 lo byte", rd_data, 16'h00B0);
        rd_ofs = 6'd0; rd_byte = 1'b0; #1 chk("R3 ofs0", rd_data, 0);
        rd_ofs = 6'd7;                 #1 chk("R3 ofs7", rd_data, 0);
    endtask

    task automatic t_errors();
        @(negedge clk);
        {bus_tmo_evt, parity_evt, misalign_evt, tick_evt} = 4'hF;
        @(negedge clk);
        {bus_tmo_evt, parity_evt, misalign_evt, tick_evt} = 4'h0;
        chk("R8 latch", csr_q, 16'hD040);
        @(negedge clk);
        chk("R8 held", csr_q, 16'hD040);
        do_wr(6'h03); chk("R4 tmo clr", csr_q, 16'h5040);
        do_wr(6'h07); chk("R4 par clr", csr_q, 16'h1040);
        do_wr(6'h0F); chk("R4 mis clr", csr_q, 16'h0040);
        @(negedge clk); tick_ack = 1'b1;
        @(negedge clk); tick_ack = 1'b0;
        chk("R8 ack", csr_q, 16'h0000);
        // collisions: set wins
        @(negedge clk);
        bus_tmo_evt = 1'b1; wr_stb = 1'b1; wr_ofs = 6'h03;
        tick_evt = 1'b1; tick_ack = 1'b1;
        @(negedge clk);
        bus_tmo_evt = 1'b0; wr_stb = 1'b0; tick_evt = 1'b0; tick_ack = 1'b0;
        chk("R8 set wins", csr_q, 16'h8040);
    endtask

    task automatic t_irq();
        @(negedge clk); dev_irq = 4'b1010;
        chk("R9 not yet", csr_q[3:0], 4'b0000);
        @(negedge clk);
        chk("R9 mirror", csr_q[3:0], 4'b1010);
        dev_irq = 4'b0101;
        @(negedge clk);
        chk("R9 follow", csr_q[3:0], 4'b0101);
        dev_irq = 4'b0000;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_pairs();
        t_undef();
        t_sysrst();
        t_reload();
        t_read();
        t_reset();
        t_errors();
        t_irq();
        t_reset();
        summary();
        $finish;
    end
endmodule